// File: doc/BRIEF.md
# I2C Slave Range Address Matcher

This block is the address-phase front end of an I2C slave. It watches SCL and SDA, which are assumed to be synchronized to the system clock already. It recognises START, repeated START and STOP conditions, and shifts in the 7-bit calling address followed by the R/W bit. The address is then compared against a primary address register. When window mode is enabled, it is also compared against a second, upper address register. On a match the block pulls SDA low for the ninth SCL pulse (ACK) and updates its status bits. It also latches an interrupt flag that software clears by writing one to it.

Both address registers use the 8-bit register form, and bit 0 is ignored. For example, programmed values 0xA0 and 0xA2 stand for the 7-bit bus addresses 0x50 and 0x51. With window mode on, the slave answers two things: the upper address, and every address strictly above the primary one up to and including the upper one. A status bit tells software whether a match came from the primary register or from the window. Each address phase yields at most one match. After the ACK, the block leaves the bus alone until the next START or STOP. Data bytes, clock stretching, 10-bit addressing and general call belong to other logic.

Top module: `i2c_range_addr_slave`

## Requirements
- R1: After reset, `sda_oe`, `addressed`, `range_hit`, `slave_rd`, `irq_flag` and `irq` are all 0.
- R2: A calling address equal to `prim_addr[7:1]` is acknowledged: `sda_oe` pulls SDA low while SCL is high on the ninth pulse. After that, `addressed` is 1 and `range_hit` is 0.
- R3: With `range_en`=1, a calling address A matches in either of two cases: A equals `range_addr[7:1]`, or `prim_addr[7:1]` < A <= `range_addr[7:1]`. Such a match that is not also a primary match is acknowledged and sets `range_hit`=1. An address outside these cases is not acknowledged.
- R4: With `range_en`=0, `range_addr` takes no part in matching. An address equal to `range_addr[7:1]` but different from the primary address gets NACK, and `addressed` stays 0.
- R5: Calling address 0 never matches through the range register or the window, so `range_hit` is set only for a nonzero address.
- R6: Every accepted match sets `irq_flag`. The output `irq` equals `irq_flag` AND `irq_en`.
- R7: On a match, `slave_rd` takes the eighth received bit (1 = master reads, 0 = master writes).
- R8: A one-cycle pulse on `flag_clr` (write-one-to-clear) clears `irq_flag` unless a new match is declared in the same cycle. `irq_flag` otherwise holds its value.
- R9: A STOP (SDA rising while SCL is high) clears `addressed` and `range_hit` and returns the block to idle.
- R10: After a non-matching address, `sda_oe` stays 0 for all further SCL pulses until the next START.
- R11: A repeated START (SDA falling while SCL is high, with no STOP in between) starts a new address phase. The status bits then reflect only the newest address, and a non-matching one clears `addressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronized SCL line |
| sda_in | input | 1 | Synchronized SDA line |
| sda_oe | output | 1 | 1 = pull SDA low (ACK) |
| prim_addr | input | 8 | Primary address, bits 7:1 used |
| range_addr | input | 8 | Range/second address, bits 7:1 used |
| range_en | input | 1 | Enables the range register and the window |
| irq_en | input | 1 | Interrupt output enable |
| flag_clr | input | 1 | Write-one pulse clearing the interrupt flag |
| addressed | output | 1 | Addressed-as-slave status |
| range_hit | output | 1 | Match came from range register or window |
| slave_rd | output | 1 | Latched R/W bit of the matched address |
| irq_flag | output | 1 | Pending address-match interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The matcher is tried against the primary address, the exact upper address with window mode both off and on, and an address inside the window. It is also tried at the addresses just below the primary and just above the upper bound. Together these separate an equality-only comparator from a window comparator, and they expose off-by-one errors at both ends of the window. Address zero with an upper register of zero shows whether the nonzero guard is present. A repeated START from a matched to a non-matching address, STOP handling, and extra bytes clocked after a NACK show that status follows only the newest address phase and that SDA is never driven without a match.

// File: rtl/i2c_range_addr_slave.sv
module i2c_range_addr_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [7:0] prim_addr,
  input  logic [7:0] range_addr,
  input  logic       range_en,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       addressed,
  output logic       range_hit,
  output logic       slave_rd,
  output logic       irq_flag,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_HOLD, S_IGNORE} state_t;

  state_t     state;
  logic       scl_q, sda_q, scl_p, sda_p;
  logic [7:0] shreg;
  logic [3:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda_in;
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  wire start_det = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_det  = scl_q & scl_p & ~sda_p & sda_q;
  wire scl_rise  = scl_q & ~scl_p;
  wire scl_fall  = ~scl_q & scl_p;

  wire [6:0] rx_addr = shreg[7:1];
  wire       rx_rw   = shreg[0];
  wire [6:0] prim7   = prim_addr[7:1];
  wire [6:0] rng7    = range_addr[7:1];

  wire prim_hit = (rx_addr == prim7);
  wire win_hit  = range_en && (rx_addr != 7'd0) &&
                  ((rx_addr == rng7) || ((rx_addr > prim7) && (rx_addr <= rng7)));

  wire eval       = (state == S_ADDR) && scl_fall && (bitcnt == 4'd8);
  wire eval_match = eval && (prim_hit || win_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      range_hit <= 1'b0;
      slave_rd  <= 1'b0;
    end else if (stop_det) begin
      state     <= S_IDLE;
      sda_oe    <= 1'b0;
      addressed <= 1'b0;
      range_hit <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end
          if (eval) begin
            if (prim_hit || win_hit) begin
              state     <= S_ACK;
              sda_oe    <= 1'b1;
              addressed <= 1'b1;
              range_hit <= ~prim_hit;
              slave_rd  <= rx_rw;
            end else begin
              state     <= S_IGNORE;
              addressed <= 1'b0;
              range_hit <= 1'b0;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            state  <= S_HOLD;
            sda_oe <= 1'b0;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_flag <= 1'b0;
    else if (eval_match) irq_flag <= 1'b1;
    else if (flag_clr)   irq_flag <= 1'b0;
  end

  assign irq = irq_flag & irq_en;

  // R10
  ack_only_when_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> addressed);

  // R9
  stop_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!addressed && !range_hit));

  // R2
  primary_not_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && prim_hit && !stop_det && !start_det) |=> (addressed && !range_hit));

  // R4
  range_off_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !range_en && !prim_hit && !stop_det && !start_det) |=> !addressed);

  // R5
  zero_never_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && (rx_addr == 7'd0) && !stop_det && !start_det) |=> !range_hit);

  // R6
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_match |=> irq_flag);

  // R8
  w1c_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !eval_match) |=> !irq_flag);

  // R3
  range_needs_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_hit |-> addressed);

endmodule

// File: tb/sim_i2c_range_addr_slave.sv
module sim_i2c_range_addr_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] prim_addr = 8'hA0, range_addr = 8'hA2;
  logic range_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic sda_oe, addressed, range_hit, slave_rd, irq_flag, irq;
  wire  sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic oe_seen = 1'b0;

  always #2.5 clk = ~clk;

  i2c_range_addr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .prim_addr(prim_addr), .range_addr(range_addr), .range_en(range_en),
    .irq_en(irq_en), .flag_clr(flag_clr), .addressed(addressed),
    .range_hit(range_hit), .slave_rd(slave_rd), .irq_flag(irq_flag), .irq(irq));

  always @(negedge clk) if (sda_oe) oe_seen <= 1'b1;

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic addr_phase(input logic [6:0] a7, input logic rw, output logic ack);
    for (int i = 6; i >= 0; i--) put_bit(a7[i]);
    put_bit(rw);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    ack = ~sda_bus;
    w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic t_reset();
    chk("R1", "sda_oe", sda_oe, 1'b0);
    chk("R1", "addressed", addressed, 1'b0);
    chk("R1", "range_hit", range_hit, 1'b0);
    chk("R1", "slave_rd", slave_rd, 1'b0);
    chk("R1", "irq_flag", irq_flag, 1'b0);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_primary();
    logic ack;
    prim_addr = 8'hA0; range_addr = 8'hA2; range_en = 1'b0; irq_en = 1'b1;
    bus_start(); addr_phase(7'h50, 1'b0, ack);
    chk("R2", "ack primary", ack, 1'b1);
    chk("R2", "addressed", addressed, 1'b1);
    chk("R2", "range_hit", range_hit, 1'b0);
    chk("R7", "slave_rd write", slave_rd, 1'b0);
    chk("R6", "irq_flag", irq_flag, 1'b1);
    chk("R6", "irq", irq, 1'b1);
    bus_stop();
    chk("R9", "addressed after stop", addressed, 1'b0);
  endtask

  task automatic t_flag();
    irq_en = 1'b0; w(2);
    chk("R6", "irq gated off", irq, 1'b0);
    chk("R8", "flag holds", irq_flag, 1'b1);
    irq_en = 1'b1; w(2);
    chk("R6", "irq gated on", irq, 1'b1);
    flag_clr = 1'b1; w(1); flag_clr = 1'b0; w(1);
    chk("R8", "flag cleared", irq_flag, 1'b0);
    chk("R8", "irq cleared", irq, 1'b0);
  endtask

  task automatic t_range_off();
    logic ack;
    range_en = 1'b0;
    bus_start(); addr_phase(7'h51, 1'b1, ack);
    chk("R4", "nack range reg disabled", ack, 1'b0);
    chk("R4", "not addressed", addressed, 1'b0);
    chk("R4", "no irq_flag", irq_flag, 1'b0);
    bus_stop();
  endtask

  task automatic t_range_eq();
    logic ack;
    range_en = 1'b1;
    bus_start(); addr_phase(7'h51, 1'b1, ack);
    chk("R3", "ack range reg", ack, 1'b1);
    chk("R3", "range_hit", range_hit, 1'b1);
    chk("R7", "slave_rd read", slave_rd, 1'b1);
    bus_stop();
    chk("R9", "range_hit after stop", range_hit, 1'b0);
    flag_clr = 1'b1; w(1); flag_clr = 1'b0; w(1);
  endtask

  task automatic t_window();
    logic ack;
    prim_addr = 8'hA0; range_addr = 8'hA8; range_en = 1'b1;
    bus_start(); addr_phase(7'h52, 1'b0, ack);
    chk("R3", "ack inside window", ack, 1'b1);
    chk("R3", "range_hit inside", range_hit, 1'b1);
    bus_stop();
    bus_start(); addr_phase(7'h54, 1'b0, ack);
    chk("R3", "ack upper bound", ack, 1'b1);
    bus_stop();
    bus_start(); addr_phase(7'h55, 1'b0, ack);
    chk("R3", "nack above window", ack, 1'b0);
    bus_stop();
    bus_start(); addr_phase(7'h4F, 1'b0, ack);
    chk("R3", "nack below primary", ack, 1'b0);
    bus_stop();
    bus_start(); addr_phase(7'h50, 1'b0, ack);
    chk("R2", "primary in window mode", ack, 1'b1);
    chk("R2", "range_hit clear for primary", range_hit, 1'b0);
    bus_stop();
  endtask

  task automatic t_zero();
    logic ack;
    prim_addr = 8'h20; range_addr = 8'h00; range_en = 1'b1;
    bus_start(); addr_phase(7'h00, 1'b0, ack);
    chk("R5", "nack zero address", ack, 1'b0);
    chk("R5", "range_hit zero", range_hit, 1'b0);
    bus_stop();
  endtask

  task automatic t_ignore();
    logic ack;
    prim_addr = 8'hA0; range_addr = 8'hA2; range_en = 1'b0;
    bus_start(); addr_phase(7'h33, 1'b0, ack);
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) put_bit(i[0]);
    for (int i = 6; i >= 0; i--) put_bit(1'(7'h50 >> i));
    put_bit(1'b0);
    put_bit(1'b1);
    chk("R10", "sda never driven after nack", oe_seen, 1'b0);
    chk("R10", "still not addressed", addressed, 1'b0);
    bus_stop();
  endtask

  task automatic t_restart();
    logic ack;
    prim_addr = 8'hA0; range_addr = 8'hA2; range_en = 1'b1;
    bus_start(); addr_phase(7'h50, 1'b0, ack);
    chk("R11", "first phase ack", ack, 1'b1);
    bus_start(); addr_phase(7'h51, 1'b1, ack);
    chk("R11", "restart range ack", ack, 1'b1);
    chk("R11", "restart range_hit", range_hit, 1'b1);
    chk("R11", "restart slave_rd", slave_rd, 1'b1);
    bus_start(); addr_phase(7'h60, 1'b0, ack);
    chk("R11", "restart nack", ack, 1'b0);
    chk("R11", "addressed cleared by nonmatch", addressed, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    w(4);
    t_reset();
    rst_n = 1'b1;
    w(4);
    t_reset();
    t_primary();
    t_flag();
    t_range_off();
    t_range_eq();
    t_window();
    t_zero();
    t_ignore();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule